// File: doc/BRIEF.md
# Reconvergence and gap learning table

This block learns, for each hard-to-predict conditional branch, where its two control paths meet again and what the region between them needs. The retiring instruction stream teaches it. When a hard branch retires, an episode opens. On the fall-through path, the first unconditional jump that retires moves the candidate meeting point to that jump's target; otherwise the meeting point is the branch's taken target. The episode closes when the retiring PC equals the candidate. It then writes an entry that holds the meeting PC, the longest path length seen so far, and the registers that the region read and wrote, accumulated as masks.

The front end uses the lookup port when it decides to skip a region. The lookup returns the meeting PC, the gap length to reserve, and the two register masks. The check port runs once a gap is filled. It compares the actual instruction count and register use against the stored entry and asks for a squash if the region did not fit.

Top module: `rgl_table`

## Requirements
- R1: The table has 128 direct-mapped entries indexed by PC bits [8:2] and tagged with the full PC. A lookup whose indexed entry is invalid or carries another tag returns look_hit_o=0 with reconvergence PC, length and both masks all zero. A newly learned entry replaces any entry with a different tag at its index.
- R2: In a not-taken episode (learn_taken_i=0), the first retired instruction with ret_jump_i=1 that comes before the candidate is reached sets the candidate to its ret_jtgt_i. Any later jump in the same episode leaves the candidate unchanged.
- R3: In a not-taken episode with no jump, the stored reconvergence PC is learn_tgt_i.
- R4: An episode closes when ret_pc_i equals the candidate. Its length is the number of retired instructions before that one. The stored length is the maximum of this length and the old length when the tag matches, and this length alone otherwise. The entry is readable on the cycle after the closing retire.
- R5: The stored input and output masks are the OR of ret_src_i and ret_dst_i over the episode's counted instructions, ORed with the old masks when the tag matches.
- R6: The length counter saturates at 31. An episode whose 31st counted instruction retires before the candidate is reached ends without writing, so the largest length ever stored is 30.
- R7: A taken episode (learn_taken_i=1) opens only if the branch PC already hits. It then uses the stored reconvergence PC as its candidate and ignores jumps. A taken start that misses has no effect on the table.
- R8: learn_start_i abandons any open episode without writing and starts a new one. Retires while no episode is open, and cycles with ret_valid_i=0, change nothing.
- R9: squash_o is 1 on the cycle after chk_valid_i=1 if chk_count_i is greater than the stored length of chk_pc_i's entry.
- R10: squash_o is 1 on the cycle after chk_valid_i=1 if chk_src_i has a bit outside the stored input mask or chk_dst_i has a bit outside the stored output mask.
- R11: squash_o is 1 on the cycle after a check whose PC misses, and 0 after any cycle without chk_valid_i or after a check that violates nothing.
- R12: After reset every entry is invalid and squash_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| learn_start_i | input | 1 | A hard branch retires; opens an episode |
| learn_pc_i | input | 32 | PC of that branch |
| learn_tgt_i | input | 32 | Taken target of that branch |
| learn_taken_i | input | 1 | Branch resolved taken |
| ret_valid_i | input | 1 | A following instruction retires |
| ret_pc_i | input | 32 | PC of the retiring instruction |
| ret_jump_i | input | 1 | The retiring instruction is an unconditional jump |
| ret_jtgt_i | input | 32 | Target of that jump |
| ret_src_i | input | 32 | Registers read, one bit per register |
| ret_dst_i | input | 32 | Registers written, one bit per register |
| look_pc_i | input | 32 | Branch PC to look up |
| look_hit_o | output | 1 | Entry valid and tag equal |
| look_reconv_o | output | 32 | Learned reconvergence PC |
| look_len_o | output | 5 | Learned gap length |
| look_in_o | output | 32 | Learned input register mask |
| look_out_o | output | 32 | Learned output register mask |
| chk_valid_i | input | 1 | A filled gap is presented for checking |
| chk_pc_i | input | 32 | Branch PC of that gap |
| chk_count_i | input | 8 | Instructions actually fetched into the gap |
| chk_src_i | input | 32 | Registers actually read in the gap |
| chk_dst_i | input | 32 | Registers actually written in the gap |
| squash_o | output | 1 | Registered squash request |

## Verification
The properties assume that squash_o only ever follows a check cycle. They also assume that a check count above 30 cannot fit any entry, that a missing lookup reads as all zeros, and that a table write happens only on a retire cycle. The stimulus keeps learn_start_i, ret_valid_i and chk_valid_i as single-cycle pulses that change only away from the clock edge. It mixes idle gaps, episodes that restart, an aliasing PC at a shared index, and a taken start on a branch the table does not hold. Path lengths reach exactly 30 and exactly 31 so that both sides of the saturation limit are covered.

// File: rtl/rgl_pkg.sv
package rgl_pkg;
  localparam int unsigned DEF_ENTRIES = 128;
  localparam int unsigned DEF_PC_W    = 32;
  localparam int unsigned DEF_NREG    = 32;
  localparam int unsigned DEF_CNT_W   = 5;
  localparam int unsigned DEF_CHK_W   = 8;
  localparam int unsigned RD_PORTS    = 3;
  localparam int unsigned RP_LOOK     = 0;
  localparam int unsigned RP_LEARN    = 1;
  localparam int unsigned RP_CHECK    = 2;
endpackage

// File: rtl/rgl_store.sv
module rgl_store #(
  parameter int unsigned ENTRIES = 128,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned NREG    = 32,
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned NRD     = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NRD-1:0][PC_W-1:0]   rd_pc_i,
  output logic [NRD-1:0]             rd_hit_o,
  output logic [NRD-1:0][PC_W-1:0]   rd_rec_o,
  output logic [NRD-1:0][CNT_W-1:0]  rd_len_o,
  output logic [NRD-1:0][NREG-1:0]   rd_in_o,
  output logic [NRD-1:0][NREG-1:0]   rd_out_o,
  input  logic                       wr_en_i,
  input  logic [PC_W-1:0]            wr_pc_i,
  input  logic [PC_W-1:0]            wr_rec_i,
  input  logic [CNT_W-1:0]           wr_len_i,
  input  logic [NREG-1:0]            wr_in_i,
  input  logic [NREG-1:0]            wr_out_i
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]  vld_q;
  logic [PC_W-1:0]     tag_q [ENTRIES];
  logic [PC_W-1:0]     rec_q [ENTRIES];
  logic [CNT_W-1:0]    len_q [ENTRIES];
  logic [NREG-1:0]     in_q  [ENTRIES];
  logic [NREG-1:0]     out_q [ENTRIES];

  logic [IDX_W-1:0] wr_idx;
  assign wr_idx = wr_pc_i[IDX_W+1:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= '0;
    else if (wr_en_i) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx] <= wr_pc_i;
      rec_q[wr_idx] <= wr_rec_i;
      len_q[wr_idx] <= wr_len_i;
      in_q[wr_idx]  <= wr_in_i;
      out_q[wr_idx] <= wr_out_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [IDX_W-1:0] idx;
    logic             hit;
    assign idx = rd_pc_i[p][IDX_W+1:2];
    assign hit = vld_q[idx] && (tag_q[idx] == rd_pc_i[p]);
    assign rd_hit_o[p] = hit;
    assign rd_rec_o[p] = hit ? rec_q[idx] : '0;
    assign rd_len_o[p] = hit ? len_q[idx] : '0;
    assign rd_in_o[p]  = hit ? in_q[idx]  : '0;
    assign rd_out_o[p] = hit ? out_q[idx] : '0;
  end
endmodule

// File: rtl/rgl_learn.sv
module rgl_learn #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned NREG  = 32,
  parameter int unsigned CNT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PC_W-1:0]   br_pc_i,
  input  logic [PC_W-1:0]   br_tgt_i,
  input  logic              taken_i,
  input  logic              ret_valid_i,
  input  logic [PC_W-1:0]   ret_pc_i,
  input  logic              ret_jump_i,
  input  logic [PC_W-1:0]   ret_jtgt_i,
  input  logic [NREG-1:0]   ret_src_i,
  input  logic [NREG-1:0]   ret_dst_i,
  output logic [PC_W-1:0]   rd_pc_o,
  input  logic              rd_hit_i,
  input  logic [PC_W-1:0]   rd_rec_i,
  input  logic [CNT_W-1:0]  rd_len_i,
  input  logic [NREG-1:0]   rd_in_i,
  input  logic [NREG-1:0]   rd_out_i,
  output logic              wr_en_o,
  output logic [PC_W-1:0]   wr_pc_o,
  output logic [PC_W-1:0]   wr_rec_o,
  output logic [CNT_W-1:0]  wr_len_o,
  output logic [NREG-1:0]   wr_in_o,
  output logic [NREG-1:0]   wr_out_o,
  output logic [PC_W-1:0]   cand_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'((2**CNT_W) - 2);

  logic              act_q, tk_q, js_q;
  logic [PC_W-1:0]   pc_q, cand_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [NREG-1:0]   src_q, dst_q;
  logic              step, close;

  assign rd_pc_o = start_i ? br_pc_i : pc_q;
  assign step    = act_q && ret_valid_i && !start_i;
  assign close   = step && (ret_pc_i == cand_q);

  assign wr_en_o  = close;
  assign wr_pc_o  = pc_q;
  assign wr_rec_o = cand_q;
  assign wr_len_o = (rd_hit_i && rd_len_i > cnt_q) ? rd_len_i : cnt_q;
  assign wr_in_o  = src_q | (rd_hit_i ? rd_in_i : '0);
  assign wr_out_o = dst_q | (rd_hit_i ? rd_out_i : '0);
  assign cand_o   = cand_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0; tk_q <= 1'b0; js_q <= 1'b0;
      pc_q <= '0; cand_q <= '0; cnt_q <= '0; src_q <= '0; dst_q <= '0;
    end else if (start_i) begin
      act_q  <= !taken_i || rd_hit_i;   // taken path needs a known meeting point
      tk_q   <= taken_i;
      js_q   <= 1'b0;
      pc_q   <= br_pc_i;
      cand_q <= taken_i ? rd_rec_i : br_tgt_i;
      cnt_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
    end else if (step) begin
      if (close || cnt_q == CNT_LAST) begin
        act_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        src_q <= src_q | ret_src_i;
        dst_q <= dst_q | ret_dst_i;
        if (!tk_q && !js_q && ret_jump_i) begin
          cand_q <= ret_jtgt_i;
          js_q   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rgl_check.sv
module rgl_check #(
  parameter int unsigned NREG  = 32,
  parameter int unsigned CNT_W = 5,
  parameter int unsigned CHK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chk_valid_i,
  input  logic [CHK_W-1:0]  chk_count_i,
  input  logic [NREG-1:0]   chk_src_i,
  input  logic [NREG-1:0]   chk_dst_i,
  input  logic              hit_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [NREG-1:0]   in_i,
  input  logic [NREG-1:0]   out_i,
  output logic              squash_o
);
  logic too_long, bad_src, bad_dst, bad;

  assign too_long = chk_count_i > CHK_W'(len_i);
  assign bad_src  = |(chk_src_i & ~in_i);
  assign bad_dst  = |(chk_dst_i & ~out_i);
  assign bad      = !hit_i || too_long || bad_src || bad_dst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) squash_o <= 1'b0;
    else         squash_o <= chk_valid_i && bad;
  end
endmodule

// File: rtl/rgl_table.sv
module rgl_table
  import rgl_pkg::*;
#(
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned PC_W    = DEF_PC_W,
  parameter int unsigned NREG    = DEF_NREG,
  parameter int unsigned CNT_W   = DEF_CNT_W,
  parameter int unsigned CHK_W   = DEF_CHK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              learn_start_i,
  input  logic [PC_W-1:0]   learn_pc_i,
  input  logic [PC_W-1:0]   learn_tgt_i,
  input  logic              learn_taken_i,
  input  logic              ret_valid_i,
  input  logic [PC_W-1:0]   ret_pc_i,
  input  logic              ret_jump_i,
  input  logic [PC_W-1:0]   ret_jtgt_i,
  input  logic [NREG-1:0]   ret_src_i,
  input  logic [NREG-1:0]   ret_dst_i,
  input  logic [PC_W-1:0]   look_pc_i,
  output logic              look_hit_o,
  output logic [PC_W-1:0]   look_reconv_o,
  output logic [CNT_W-1:0]  look_len_o,
  output logic [NREG-1:0]   look_in_o,
  output logic [NREG-1:0]   look_out_o,
  input  logic              chk_valid_i,
  input  logic [PC_W-1:0]   chk_pc_i,
  input  logic [CHK_W-1:0]  chk_count_i,
  input  logic [NREG-1:0]   chk_src_i,
  input  logic [NREG-1:0]   chk_dst_i,
  output logic              squash_o
);
  logic [RD_PORTS-1:0][PC_W-1:0]  rd_pc;
  logic [RD_PORTS-1:0]            rd_hit;
  logic [RD_PORTS-1:0][PC_W-1:0]  rd_rec;
  logic [RD_PORTS-1:0][CNT_W-1:0] rd_len;
  logic [RD_PORTS-1:0][NREG-1:0]  rd_in, rd_out;

  logic              wr_en;
  logic [PC_W-1:0]   wr_pc, wr_rec, learn_rd_pc, cand;
  logic [CNT_W-1:0]  wr_len;
  logic [NREG-1:0]   wr_in, wr_out;

  assign rd_pc[RP_LOOK]  = look_pc_i;
  assign rd_pc[RP_LEARN] = learn_rd_pc;
  assign rd_pc[RP_CHECK] = chk_pc_i;

  rgl_store #(.ENTRIES(ENTRIES), .PC_W(PC_W), .NREG(NREG), .CNT_W(CNT_W), .NRD(RD_PORTS)) u_store (
    .clk_i, .rst_ni,
    .rd_pc_i(rd_pc), .rd_hit_o(rd_hit), .rd_rec_o(rd_rec), .rd_len_o(rd_len),
    .rd_in_o(rd_in), .rd_out_o(rd_out),
    .wr_en_i(wr_en), .wr_pc_i(wr_pc), .wr_rec_i(wr_rec), .wr_len_i(wr_len),
    .wr_in_i(wr_in), .wr_out_i(wr_out)
  );

  rgl_learn #(.PC_W(PC_W), .NREG(NREG), .CNT_W(CNT_W)) u_learn (
    .clk_i, .rst_ni,
    .start_i(learn_start_i), .br_pc_i(learn_pc_i), .br_tgt_i(learn_tgt_i), .taken_i(learn_taken_i),
    .ret_valid_i, .ret_pc_i, .ret_jump_i, .ret_jtgt_i, .ret_src_i, .ret_dst_i,
    .rd_pc_o(learn_rd_pc), .rd_hit_i(rd_hit[RP_LEARN]), .rd_rec_i(rd_rec[RP_LEARN]),
    .rd_len_i(rd_len[RP_LEARN]), .rd_in_i(rd_in[RP_LEARN]), .rd_out_i(rd_out[RP_LEARN]),
    .wr_en_o(wr_en), .wr_pc_o(wr_pc), .wr_rec_o(wr_rec), .wr_len_o(wr_len),
    .wr_in_o(wr_in), .wr_out_o(wr_out), .cand_o(cand)
  );

  rgl_check #(.NREG(NREG), .CNT_W(CNT_W), .CHK_W(CHK_W)) u_check (
    .clk_i, .rst_ni,
    .chk_valid_i, .chk_count_i, .chk_src_i, .chk_dst_i,
    .hit_i(rd_hit[RP_CHECK]), .len_i(rd_len[RP_CHECK]),
    .in_i(rd_in[RP_CHECK]), .out_i(rd_out[RP_CHECK]),
    .squash_o
  );

  assign look_hit_o    = rd_hit[RP_LOOK];
  assign look_reconv_o = rd_rec[RP_LOOK];
  assign look_len_o    = rd_len[RP_LOOK];
  assign look_in_o     = rd_in[RP_LOOK];
  assign look_out_o    = rd_out[RP_LOOK];
endmodule

// File: rtl/rgl_table_chk.sv
module rgl_table_chk #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned NREG  = 32,
  parameter int unsigned CNT_W = 5,
  parameter int unsigned CHK_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              chk_valid_i,
  input logic [CHK_W-1:0]  chk_count_i,
  input logic              squash_o,
  input logic              look_hit_o,
  input logic [PC_W-1:0]   look_reconv_o,
  input logic [CNT_W-1:0]  look_len_o,
  input logic [NREG-1:0]   look_in_o,
  input logic [NREG-1:0]   look_out_o,
  input logic              ret_valid_i,
  input logic              wr_en
);
  localparam int unsigned LEN_CAP = (2**CNT_W) - 2;

  // R11
  squash_after_chk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_valid_i |=> !squash_o);

  // R1
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !look_hit_o |-> (look_reconv_o == '0 && look_len_o == '0 && look_in_o == '0 && look_out_o == '0));

  // R6
  len_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    look_hit_o |-> (int'(look_len_o) <= LEN_CAP));

  // R9
  over_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_valid_i && int'(chk_count_i) > LEN_CAP) |=> squash_o);

  // R8
  wr_on_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> ret_valid_i);
endmodule

bind rgl_table rgl_table_chk #(.PC_W(PC_W), .NREG(NREG), .CNT_W(CNT_W), .CHK_W(CHK_W)) u_rgl_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .chk_valid_i(chk_valid_i), .chk_count_i(chk_count_i),
  .squash_o(squash_o), .look_hit_o(look_hit_o), .look_reconv_o(look_reconv_o),
  .look_len_o(look_len_o), .look_in_o(look_in_o), .look_out_o(look_out_o),
  .ret_valid_i(ret_valid_i), .wr_en(wr_en)
);

// File: tb/tb_rgl_table.sv
module tb_rgl_table;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic learn_start_i = 0, learn_taken_i = 0, ret_valid_i = 0, ret_jump_i = 0, chk_valid_i = 0;
  logic [31:0] learn_pc_i = 0, learn_tgt_i = 0, ret_pc_i = 0, ret_jtgt_i = 0;
  logic [31:0] ret_src_i = 0, ret_dst_i = 0, look_pc_i = 0, chk_pc_i = 0, chk_src_i = 0, chk_dst_i = 0;
  logic [7:0]  chk_count_i = 0;
  logic        look_hit_o, squash_o;
  logic [31:0] look_reconv_o, look_in_o, look_out_o;
  logic [4:0]  look_len_o;

  rgl_table dut (.*);

  // reference model
  bit          m_vld [128];
  int unsigned m_tag [128], m_rec [128], m_len [128], m_in [128], m_out [128];
  bit          e_act, e_tk, e_js, m_sq;
  int unsigned e_pc, e_cand, e_cnt, e_src, e_dst;

  function automatic int ix(input int unsigned pc);
    return (pc >> 2) % 128;
  endfunction

  function automatic bit mhit(input int unsigned pc);
    return m_vld[ix(pc)] && m_tag[ix(pc)] == pc;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_vld[k]) m_vld[k] = 0;
      e_act = 0; m_sq = 0;
    end else begin
      if (chk_valid_i) begin
        int k; k = ix(chk_pc_i);
        if (!mhit(chk_pc_i)) m_sq = 1;
        else m_sq = (chk_count_i > m_len[k]) || ((chk_src_i & ~m_in[k]) != 0) || ((chk_dst_i & ~m_out[k]) != 0);
      end else m_sq = 0;
      if (learn_start_i) begin
        e_pc = learn_pc_i; e_tk = learn_taken_i; e_js = 0; e_cnt = 0; e_src = 0; e_dst = 0;
        if (!learn_taken_i) begin e_act = 1; e_cand = learn_tgt_i; end
        else if (mhit(learn_pc_i)) begin e_act = 1; e_cand = m_rec[ix(learn_pc_i)]; end
        else e_act = 0;
      end else if (e_act && ret_valid_i) begin
        if (ret_pc_i == e_cand) begin
          int k; k = ix(e_pc);
          if (mhit(e_pc)) begin
            m_len[k] = (m_len[k] > e_cnt) ? m_len[k] : e_cnt;
            m_in[k] |= e_src; m_out[k] |= e_dst;
          end else begin
            m_len[k] = e_cnt; m_in[k] = e_src; m_out[k] = e_dst;
          end
          m_vld[k] = 1; m_tag[k] = e_pc; m_rec[k] = e_cand;
          e_act = 0;
        end else if (e_cnt == 30) begin
          e_act = 0;
        end else begin
          e_cnt++; e_src |= ret_src_i; e_dst |= ret_dst_i;
          if (!e_tk && !e_js && ret_jump_i) begin e_cand = ret_jtgt_i; e_js = 1; end
        end
      end
    end
  end

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R12";
  bit    done = 0;

  task automatic cmp(input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit h; int k;
    h = mhit(look_pc_i); k = ix(look_pc_i);
    cmp("hit", look_hit_o, h);
    cmp("reconv", look_reconv_o, h ? m_rec[k] : 0);
    cmp("len", look_len_o, h ? m_len[k] : 0);
    cmp("in", look_in_o, h ? m_in[k] : 0);
    cmp("out", look_out_o, h ? m_out[k] : 0);
    cmp("squash", squash_o, m_sq);
  endtask

  task automatic tick();
    @(negedge clk_i);
    compare();
  endtask

  task automatic start(input int unsigned pc, input int unsigned tgt, input bit tk);
    learn_start_i = 1; learn_pc_i = pc; learn_tgt_i = tgt; learn_taken_i = tk; look_pc_i = pc;
    tick();
    learn_start_i = 0;
  endtask

  task automatic ret(input int unsigned pc, input bit j = 0, input int unsigned jt = 0,
                     input int unsigned s = 0, input int unsigned d = 0);
    ret_valid_i = 1; ret_pc_i = pc; ret_jump_i = j; ret_jtgt_i = jt; ret_src_i = s; ret_dst_i = d;
    tick();
    ret_valid_i = 0; ret_jump_i = 0;
  endtask

  task automatic chk(input int unsigned pc, input int unsigned n, input int unsigned s, input int unsigned d);
    chk_valid_i = 1; chk_pc_i = pc; chk_count_i = 8'(n); chk_src_i = s; chk_dst_i = d;
    tick();
    chk_valid_i = 0;
    tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    cur_req = "R12"; look_pc_i = 32'h100; idle(2);

    // R2: if-then-else on fall-through, jump target becomes meeting point
    cur_req = "R2";
    start(32'h100, 32'h120, 0);
    ret(32'h104, 0, 0, 32'h2, 32'h8);
    idle(1);
    ret(32'h108, 0, 0, 32'h4, 32'h0);
    ret(32'h10c, 1, 32'h140, 0, 0);
    ret(32'h140);
    idle(2);

    // R4 R5 R7: taken path of same branch, longer, merges masks
    cur_req = "R4";
    start(32'h100, 32'h120, 1);
    ret(32'h120, 1, 32'h999, 32'h10, 32'h100);
    ret(32'h124, 0, 0, 32'h20, 0);
    ret(32'h128); ret(32'h12c); ret(32'h130);
    cur_req = "R5";
    ret(32'h140);
    idle(1);
    // R4: shorter fall-through episode keeps max length
    cur_req = "R4";
    start(32'h100, 32'h120, 0);
    ret(32'h104, 1, 32'h140); ret(32'h140);
    idle(1);

    // R3: plain if
    cur_req = "R3";
    start(32'h200, 32'h210, 0);
    ret(32'h204, 0, 0, 32'h1, 32'h1); ret(32'h208); ret(32'h20c); ret(32'h210);
    idle(1);

    // R7: taken start that misses changes nothing
    cur_req = "R7";
    start(32'ha00, 32'ha40, 1);
    ret(32'ha40); ret(32'ha44);
    idle(1);

    // R6: 31 instructions abandon the episode
    cur_req = "R6";
    start(32'h300, 32'h400, 0);
    for (int i = 1; i <= 31; i++) ret(32'h300 + 4 * i);
    ret(32'h400);
    idle(1);
    look_pc_i = 32'h100; idle(1);
    // R6: exactly 30 is stored
    start(32'h600, 32'h700, 0);
    for (int i = 1; i <= 30; i++) ret(32'h600 + 4 * i, 0, 0, 32'h1 << (i % 32), 0);
    ret(32'h700);
    idle(1);

    // R8: restart abandons the open episode
    cur_req = "R8";
    start(32'h800, 32'h900, 0);
    ret(32'h804); ret(32'h808);
    start(32'h840, 32'h860, 0);
    ret(32'h844); ret(32'h860);
    ret(32'h900);
    look_pc_i = 32'h800; idle(2);
    look_pc_i = 32'h840; idle(1);

    // R9 R10 R11: gap checks against 0x100 (len 5, in 0x36, out 0x108)
    look_pc_i = 32'h100;
    cur_req = "R11"; chk(32'h100, 5, 32'h32, 32'h100);
    cur_req = "R9";  chk(32'h100, 6, 32'h2, 32'h8);
    chk(32'h100, 40, 0, 0);
    chk(32'h600, 30, 0, 0);
    chk(32'h600, 31, 0, 0);
    cur_req = "R10"; chk(32'h100, 2, 32'h40, 0);
    chk(32'h100, 2, 0, 32'h1);
    cur_req = "R11"; chk(32'hb00, 0, 0, 0);
    chk(32'h200, 3, 32'h1, 32'h1);

    // R1: aliasing PC at the same index replaces the entry
    cur_req = "R1";
    start(32'h500, 32'h510, 0);
    ret(32'h504); ret(32'h510);
    look_pc_i = 32'h100; idle(1);
    look_pc_i = 32'h500; idle(1);
    chk(32'h100, 0, 0, 0);
    idle(2);
    finish_run();
  end
endmodule